// File: doc/BRIEF.md
# Per-Input Circular Page Allocator

This block tracks where one signal input writes into its own region of a large page-addressed sample buffer. Software sets a region as a first page plus a page count. It also sets a record control that starts recording, or stops it and freezes the stored data. While recording, each page-done event from the upstream packer is answered in the same cycle with the page address to write. The pointer then moves on and wraps to the first page of the region once the region is used up. Addresses also wrap at the top of the 21-bit page space, so a region may straddle the end of memory.

The block keeps a status view for readout: the page index and sequence number of the most recent page written, a count of fresh pages held that saturates at the region size, a full flag, and a recording flag. One instance serves each input. Arbitration among the inputs and the memory interface lie outside this block.

Top module: `page_ring_tracker`

## Requirements
- R1: After reset the block is not recording, issues no write, and shows zero for the last page index, the last sequence number and the fresh-page count. The full flag is low.
- R2: With an allocated page count of zero, a true record control never brings the block into recording, and page-done events issue no write.
- R3: With a nonzero allocated count, the recording output goes high on the clock edge that samples the record control as true while stopped.
- R4: While recording, a page-done event raises `wrValid` in the same cycle, and `wrAddr` carries the current pointer. The first address after an allocation is the start page.
- R5: After the page at start + count - 1 (modulo 2^21), the next address is the start page again.
- R6: Page addresses wrap from 2^21 - 1 to 0, so a region that crosses the top of memory stays contiguous.
- R7: The fresh-page count rises by one per written page and holds at the allocated count. `full` is high exactly when that count equals a nonzero allocation.
- R8: On the clock edge that ends a write cycle, `lastPage` takes the address just issued and `lastSeq` takes the sequence number given with that event.
- R9: The recording output falls on the clock edge that samples the record control as false. From then on, page-done events issue no write and leave `lastPage`, `lastSeq` and the fresh-page count unchanged.
- R10: Resuming after a freeze continues from the page after the last one written, and the fresh-page count is kept, not cleared.
- R11: An allocation apply pulse takes effect only while stopped. It loads the region, sets the pointer to the start page and clears the fresh-page count. While recording, the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | 21 | First page of the region to load |
| cfgCount | input | 22 | Page count of the region to load (0 = no buffer) |
| cfgApply | input | 1 | One-cycle pulse that loads cfgStart/cfgCount while stopped |
| recordEn | input | 1 | Record control: 1 record, 0 stop and freeze |
| pageDone | input | 1 | One page of data is ready to be stored |
| pageSeq | input | 64 | Sequence number of the page flagged by pageDone |
| wrValid | output | 1 | A write to wrAddr is issued this cycle |
| wrAddr | output | 21 | Page address for the current write |
| recording | output | 1 | Block is in the recording state |
| lastPage | output | 21 | Page index of the most recent write |
| lastSeq | output | 64 | Sequence number of the most recent write |
| freshCount | output | 22 | Number of fresh pages held, saturating at the region size |
| full | output | 1 | Region holds only fresh data |

## Verification
A pointer that has slipped shows up on `wrAddr` at the very next page-done event. A missed wrap point shows up within one region length of writes. A wrong freeze or apply decision shows up either as a `wrValid` that should not occur, in the same cycle as the page-done event, or as a write address that continues from the wrong page. A fresh-page counter that fails to saturate or fails to clear shows up on `freshCount` and `full` one edge after the write or apply that should have held or cleared it.

// File: rtl/page_ring_pkg.sv
package page_ring_pkg;

  typedef enum logic [1:0] {
    ST_RESET  = 2'd0,
    ST_STOP   = 2'd1,
    ST_RECORD = 2'd2
  } ringState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic advance;
  } ringStrobe_t;

endpackage

// File: rtl/page_ring_ctrl.sv
module page_ring_ctrl
  import page_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        recordEn,
  input  logic        cfgApply,
  input  logic        pageDone,
  input  logic        regionEmpty,
  output ringStrobe_t strobe,
  output logic        recording
);

  ringState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RESET:  stateNext = ST_STOP;
      ST_STOP:   if (recordEn && !regionEmpty) stateNext = ST_RECORD;
      ST_RECORD: if (!recordEn) stateNext = ST_STOP;
      default:   stateNext = ST_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RESET;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.loadCfg = cfgApply && (state == ST_STOP);
    strobe.advance = pageDone && (state == ST_RECORD);
  end

  assign recording = (state == ST_RECORD);

endmodule

// File: rtl/page_ring_dp.sv
module page_ring_dp
  import page_ring_pkg::*;
#(
  parameter int PAGE_W = 21,
  parameter int SEQ_W  = 64,
  localparam int CNT_W = PAGE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic [PAGE_W-1:0] cfgStart,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [SEQ_W-1:0]  pageSeq,
  output logic [PAGE_W-1:0] curPtr,
  output logic [PAGE_W-1:0] lastPage,
  output logic [SEQ_W-1:0]  lastSeq,
  output logic [CNT_W-1:0]  freshCount,
  output logic              regionEmpty,
  output logic              full
);

  logic [PAGE_W-1:0] regStart;
  logic [CNT_W-1:0]  regCount;
  logic [CNT_W-1:0]  offset;
  logic              atRegionEnd;

  assign atRegionEnd = (offset == regCount - 1'b1);
  assign regionEmpty = (regCount == '0);
  assign full        = !regionEmpty && (freshCount == regCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regStart   <= '0;
      regCount   <= '0;
      offset     <= '0;
      curPtr     <= '0;
      lastPage   <= '0;
      lastSeq    <= '0;
      freshCount <= '0;
    end else if (strobe.loadCfg) begin
      regStart   <= cfgStart;
      regCount   <= cfgCount;
      offset     <= '0;
      curPtr     <= cfgStart;
      freshCount <= '0;
    end else if (strobe.advance) begin
      lastPage <= curPtr;
      lastSeq  <= pageSeq;
      if (freshCount != regCount) freshCount <= freshCount + 1'b1;
      if (atRegionEnd) begin
        offset <= '0;
        curPtr <= regStart;
      end else begin
        offset <= offset + 1'b1;
        curPtr <= curPtr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/page_ring_tracker.sv
module page_ring_tracker
  import page_ring_pkg::*;
#(
  parameter int PAGE_W = 21,
  parameter int SEQ_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] cfgStart,
  input  logic [PAGE_W:0]   cfgCount,
  input  logic              cfgApply,
  input  logic              recordEn,
  input  logic              pageDone,
  input  logic [SEQ_W-1:0]  pageSeq,
  output logic              wrValid,
  output logic [PAGE_W-1:0] wrAddr,
  output logic              recording,
  output logic [PAGE_W-1:0] lastPage,
  output logic [SEQ_W-1:0]  lastSeq,
  output logic [PAGE_W:0]   freshCount,
  output logic              full
);

  ringStrobe_t strobe;
  logic        regionEmpty;

  page_ring_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .recordEn   (recordEn),
    .cfgApply   (cfgApply),
    .pageDone   (pageDone),
    .regionEmpty(regionEmpty),
    .strobe     (strobe),
    .recording  (recording)
  );

  page_ring_dp #(.PAGE_W(PAGE_W), .SEQ_W(SEQ_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgStart   (cfgStart),
    .cfgCount   (cfgCount),
    .pageSeq    (pageSeq),
    .curPtr     (wrAddr),
    .lastPage   (lastPage),
    .lastSeq    (lastSeq),
    .freshCount (freshCount),
    .regionEmpty(regionEmpty),
    .full       (full)
  );

  assign wrValid = strobe.advance;

endmodule

// File: rtl/page_ring_checker.sv
module page_ring_checker #(
  parameter int PAGE_W = 21,
  parameter int SEQ_W  = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgApply,
  input logic [SEQ_W-1:0]  pageSeq,
  input logic              wrValid,
  input logic [PAGE_W-1:0] wrAddr,
  input logic              recording,
  input logic [PAGE_W-1:0] lastPage,
  input logic [SEQ_W-1:0]  lastSeq,
  input logic [PAGE_W:0]   freshCount,
  input logic              full
);

  // R9
  no_write_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    !recording |-> !wrValid);

  // R8
  last_page_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> lastPage == $past(wrAddr));

  // R8
  last_seq_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> lastSeq == $past(pageSeq));

  // R7
  full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && full) |=> full);

  // R9
  fresh_idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrValid && !cfgApply) |=> $stable(freshCount));

  // R7
  full_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> freshCount != '0);

endmodule

bind page_ring_tracker page_ring_checker #(.PAGE_W(PAGE_W), .SEQ_W(SEQ_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgApply  (cfgApply),
  .pageSeq   (pageSeq),
  .wrValid   (wrValid),
  .wrAddr    (wrAddr),
  .recording (recording),
  .lastPage  (lastPage),
  .lastSeq   (lastSeq),
  .freshCount(freshCount),
  .full      (full)
);

// File: tb/page_ring_tracker_tb.sv
module page_ring_tracker_tb;

  localparam int PW = 21;
  localparam int SW = 64;
  localparam longint SPACE = longint'(1) << PW;

  logic          clk = 0;
  logic          rstN = 0;
  logic [PW-1:0] cfgStart = '0;
  logic [PW:0]   cfgCount = '0;
  logic          cfgApply = 0;
  logic          recordEn = 0;
  logic          pageDone = 0;
  logic [SW-1:0] pageSeq = '0;
  logic          wrValid;
  logic [PW-1:0] wrAddr;
  logic          recording;
  logic [PW-1:0] lastPage;
  logic [SW-1:0] lastSeq;
  logic [PW:0]   freshCount;
  logic          full;

  int tests = 0;
  int fails = 0;

  // independent model
  longint mStart = 0, mCount = 0, mOff = 0, mFresh = 0, mLastPage = 0;
  logic [SW-1:0] mLastSeq = '0;
  bit mRec = 0;

  logic [PW-1:0] expQ[$];

  always #4 clk = ~clk;

  page_ring_tracker u_dut (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgCount(cfgCount),
    .cfgApply(cfgApply), .recordEn(recordEn), .pageDone(pageDone),
    .pageSeq(pageSeq), .wrValid(wrValid), .wrAddr(wrAddr),
    .recording(recording), .lastPage(lastPage), .lastSeq(lastSeq),
    .freshCount(freshCount), .full(full)
  );

  task automatic check(input string rq, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected address per observed write
  always @(negedge clk) begin
    if (rstN && wrValid) begin
      tests++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R4: actual write to %0d expected no write", wrAddr);
      end else begin
        logic [PW-1:0] e;
        e = expQ.pop_front();
        if (wrAddr != e) begin
          fails++;
          $display("FAIL R4/R5/R6: actual addr %0d expected %0d", wrAddr, e);
        end
      end
    end
  end

  task automatic checkStatus(input string rq);
    @(negedge clk);
    check({rq, " recording"}, recording, mRec);
    check({rq, " freshCount"}, freshCount, mFresh);
    check({rq, " full"}, full, (mCount != 0) && (mFresh == mCount));
    check({rq, " lastPage"}, lastPage, mLastPage);
    check({rq, " lastSeq"}, lastSeq, mLastSeq);
  endtask

  task automatic setRec(input bit v, input string rq);
    @(posedge clk); #1 recordEn = v;
    @(posedge clk); #1;
    if (v) mRec = (mCount != 0);
    else   mRec = 0;
    checkStatus(rq);
  endtask

  task automatic applyCfg(input longint s, input longint c, input string rq);
    @(posedge clk); #1;
    cfgStart = PW'(s); cfgCount = (PW+1)'(c); cfgApply = 1;
    @(posedge clk); #1 cfgApply = 0;
    if (!mRec) begin
      mStart = s; mCount = c; mOff = 0; mFresh = 0;
    end
    checkStatus(rq);
  endtask

  task automatic page(input logic [SW-1:0] seq, input string rq);
    longint a;
    a = (mStart + mOff) % SPACE;
    @(posedge clk); #1;
    pageDone = 1; pageSeq = seq;
    if (mRec) expQ.push_back(PW'(a));
    @(negedge clk);
    check({rq, " wrValid"}, wrValid, mRec);
    @(posedge clk); #1 pageDone = 0;
    if (mRec) begin
      mLastPage = a; mLastSeq = seq;
      if (mFresh != mCount) mFresh++;
      mOff = (mOff == mCount - 1) ? 0 : mOff + 1;
    end
    checkStatus(rq);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    repeat (2) @(posedge clk);
    // R1 reset state
    checkStatus("R1");
    @(negedge clk);
    check("R1 wrValid", wrValid, 0);

    // R2 zero allocation never records
    setRec(1, "R2");
    page(64'h11, "R2");
    setRec(0, "R2");

    // R11 apply in stop, R3 start recording
    applyCfg(100, 4, "R11");
    setRec(1, "R3");
    // R4 R5 R7 R8: six pages through a region of four
    for (int i = 0; i < 6; i++) page(64'h1000 + i, "R5_R7_R8");

    // R11 apply while recording is ignored
    applyCfg(500, 2, "R11");
    page(64'h2000, "R11");

    // R9 freeze
    setRec(0, "R9");
    page(64'h3000, "R9");
    page(64'h3001, "R9");

    // R10 resume keeps position and fresh count
    setRec(1, "R10");
    page(64'h4000, "R10");

    // R6 region across top of page space
    setRec(0, "R9");
    applyCfg(SPACE - 2, 5, "R11");
    setRec(1, "R3");
    for (int i = 0; i < 6; i++) page(64'h5000 + i, "R6_R7");

    repeat (3) @(posedge clk);
    check("R4 scoreboard empty", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule